// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block runs hardware handshake for one serial channel. On the receive side it decides whether the local request-to-send line is asserted. It compares the receive FIFO fill count against two thresholds that differ from each other. Crossing the upper one withdraws the request. The request returns only after the count has drained down to the lower one. Because the two thresholds differ, the line does not toggle on every word.

In the 32-entry FIFO mode, both thresholds come from a fixed table selected by a two-bit trigger code. In the 128-entry mode, they come from two programmable level inputs.

On the transmit side, the block synchronises the clear-to-send input from the remote end. A rising edge of that input means the far buffer is nearly full. Such an edge sets a sticky status flag if the interrupt enable allows it, and a host status read clears the flag. When automatic CTS handling is on and the line is high, the block holds the transmitter. The hold only takes effect at a character boundary, so a character already in progress finishes first.

Top module: `rtsc_flow_ctrl`

## Requirements
- R1: With `auto_rts_en`=0, `rts_out` equals `sw_rts` in the same cycle. With `auto_rts_en`=1, `rts_out` shows the hysteresis state, where 1 means asserted (ready to receive).
- R2: In 32-entry mode (`wide_mode`=0), the trigger code selects the thresholds: code 0 gives 8/0, code 1 gives 16/7, code 2 gives 24/15, and code 3 gives 28/23 (withdraw/re-assert). The state withdraws one clock after `rx_level` is at or above the withdraw value. It re-asserts one clock after `rx_level` is at or below the re-assert value.
- R3: While `rx_level` lies strictly between the two thresholds, the RTS state keeps its previous value.
- R4: In 128-entry mode (`wide_mode`=1), the withdraw threshold is `wm_neg_lvl` and the re-assert threshold is `wm_asr_lvl`, with the same timing as R2.
- R5: `cts_pin` passes through a two-flop synchroniser. A 0-to-1 change sets `cts_flag` at the third rising clock edge after the change, provided `cts_irq_en`=1.
- R6: With `cts_irq_en`=0, a CTS rising edge leaves `cts_flag` at 0.
- R7: A `status_rd` pulse clears `cts_flag` at the next edge. If a pending set arrives at that same edge, the set wins.
- R8: With `auto_cts_en`=1, `tx_hold` rises at the first edge where the synchronised CTS is 1 and `tx_idle`=1, and stays 1 while CTS stays high. It falls at the third edge after `cts_pin` returns to 0. With `auto_cts_en`=0, `tx_hold` is 0.
- R9: After reset, the RTS state is asserted, and `cts_flag` and `tx_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | CNT_W | Receive FIFO fill count |
| wide_mode | input | 1 | 1 = 128-entry mode with programmable levels |
| rx_trig_code | input | 2 | Trigger code for the 32-entry table |
| wm_neg_lvl | input | CNT_W | Withdraw level in 128-entry mode |
| wm_asr_lvl | input | CNT_W | Re-assert level in 128-entry mode |
| auto_rts_en | input | 1 | Automatic RTS enable |
| sw_rts | input | 1 | Software RTS value used when automatic RTS is off |
| auto_cts_en | input | 1 | Automatic CTS enable |
| cts_irq_en | input | 1 | Interrupt enable for CTS rising edges |
| cts_pin | input | 1 | Asynchronous clear-to-send input |
| tx_idle | input | 1 | 1 when no character is in progress |
| status_rd | input | 1 | Host status read pulse, clears the flag |
| rts_out | output | 1 | Request-to-send, 1 = asserted |
| tx_hold | output | 1 | Holds the transmitter |
| cts_flag | output | 1 | Sticky CTS-rise status bit |

## Verification
The hardest case to reach is a status read that lands on the same edge as a flag set. The set happens two synchroniser stages and one edge-detect register after the pin moves. The stimulus counts exactly two edges after raising `cts_pin`, then drives `status_rd` for the third edge, and expects the flag to survive. Hysteresis is exercised by walking `rx_level` up and down across each table row. Between the thresholds, the bench checks that the output keeps whichever direction it last moved.

// File: rtl/fc_pkg.sv
package fc_pkg;
   localparam int TBL_W = 8;

   // withdraw threshold of the 32-entry table
   function automatic logic [TBL_W-1:0] tbl_neg(input logic [1:0] code);
      logic [TBL_W-1:0] v;
      if (code == 2'd3) v = TBL_W'(28);
      else              v = TBL_W'((int'(code) + 1) * 8);
      return v;
   endfunction

   // re-assert threshold of the 32-entry table
   function automatic logic [TBL_W-1:0] tbl_asr(input logic [1:0] code);
      logic [TBL_W-1:0] v;
      if (code == 2'd0) v = '0;
      else              v = TBL_W'(int'(code) * 8 - 1);
      return v;
   endfunction
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else if (g == 0) chain[g] <= d_in;
            else chain[g] <= chain[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] lvl,
   input  logic [CNT_W-1:0] neg_thr,
   input  logic [CNT_W-1:0] asr_thr,
   output logic             rts_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rts_on <= 1'b1;
      else if (lvl >= neg_thr)   rts_on <= 1'b0;
      else if (lvl <= asr_thr)   rts_on <= 1'b1;
   end
endmodule

// File: rtl/fc_cts_ctrl.sv
module fc_cts_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_s,
   input  logic auto_cts_en,
   input  logic irq_en,
   input  logic status_rd,
   input  logic tx_idle,
   output logic cts_rise,
   output logic cts_flag,
   output logic tx_hold
);
   logic cts_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cts_d <= 1'b0;
      else        cts_d <= cts_s;
   end

   assign cts_rise = cts_s & ~cts_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cts_flag <= 1'b0;
      else if (cts_rise && irq_en) cts_flag <= 1'b1;
      else if (status_rd)         cts_flag <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     tx_hold <= 1'b0;
      else if (!auto_cts_en || !cts_s) tx_hold <= 1'b0;
      else if (tx_idle)               tx_hold <= 1'b1;
   end
endmodule

// File: rtl/rtsc_flow_ctrl.sv
module rtsc_flow_ctrl #(
   parameter int CNT_W       = 8,
   parameter int WIDE_DEPTH  = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_level,
   input  logic             wide_mode,
   input  logic [1:0]       rx_trig_code,
   input  logic [CNT_W-1:0] wm_neg_lvl,
   input  logic [CNT_W-1:0] wm_asr_lvl,
   input  logic             auto_rts_en,
   input  logic             sw_rts,
   input  logic             auto_cts_en,
   input  logic             cts_irq_en,
   input  logic             cts_pin,
   input  logic             tx_idle,
   input  logic             status_rd,
   output logic             rts_out,
   output logic             tx_hold,
   output logic             cts_flag
);
   localparam int MIN_W = $clog2(WIDE_DEPTH + 1);

   generate
      if (CNT_W < MIN_W) begin : g_bad_w
         $error("CNT_W too narrow for WIDE_DEPTH");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < fc_pkg::TBL_W) begin : g_bad_tbl
         $error("CNT_W must hold the table thresholds");
      end
   endgenerate

   logic [CNT_W-1:0] neg_thr, asr_thr;
   logic             rts_on, cts_s, cts_rise;

   always_comb begin
      if (wide_mode) begin
         neg_thr = wm_neg_lvl;
         asr_thr = wm_asr_lvl;
      end else begin
         neg_thr = CNT_W'(fc_pkg::tbl_neg(rx_trig_code));
         asr_thr = CNT_W'(fc_pkg::tbl_asr(rx_trig_code));
      end
   end

   fc_rts_hyst #(.CNT_W(CNT_W)) u_hyst (
      .clk(clk), .rst_n(rst_n), .lvl(rx_level),
      .neg_thr(neg_thr), .asr_thr(asr_thr), .rts_on(rts_on)
   );

   assign rts_out = auto_rts_en ? rts_on : sw_rts;

   fc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(cts_pin), .q_out(cts_s)
   );

   fc_cts_ctrl u_cts (
      .clk(clk), .rst_n(rst_n), .cts_s(cts_s), .auto_cts_en(auto_cts_en),
      .irq_en(cts_irq_en), .status_rd(status_rd), .tx_idle(tx_idle),
      .cts_rise(cts_rise), .cts_flag(cts_flag), .tx_hold(tx_hold)
   );
endmodule

// File: rtl/fc_flow_chk.sv
module fc_flow_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] rx_level,
   input logic [CNT_W-1:0] neg_thr,
   input logic [CNT_W-1:0] asr_thr,
   input logic             rts_on,
   input logic             cts_rise,
   input logic             cts_irq_en,
   input logic             status_rd,
   input logic             auto_cts_en,
   input logic             tx_idle,
   input logic             tx_hold,
   input logic             cts_flag
);
   // R2
   rts_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level >= neg_thr) |=> !rts_on);

   // R3
   rts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level > asr_thr && rx_level < neg_thr) |=> $stable(rts_on));

   // R4
   rts_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rts_on && rx_level <= asr_thr && rx_level < neg_thr) |=> rts_on);

   // R6
   flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cts_irq_en && !cts_flag) |=> !cts_flag);

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_rd && !cts_rise) |=> !cts_flag);

   // R8
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_cts_en |=> !tx_hold);

   // R8
   hold_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_hold) |-> $past(tx_idle));
endmodule

bind rtsc_flow_ctrl fc_flow_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .neg_thr(neg_thr),
   .asr_thr(asr_thr), .rts_on(rts_on), .cts_rise(cts_rise),
   .cts_irq_en(cts_irq_en), .status_rd(status_rd), .auto_cts_en(auto_cts_en),
   .tx_idle(tx_idle), .tx_hold(tx_hold), .cts_flag(cts_flag)
);

// File: tb/rtsc_flow_ctrl_bench.sv
module rtsc_flow_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] rx_level = '0;
   logic wide_mode = 1'b0;
   logic [1:0] rx_trig_code = 2'd0;
   logic [CW-1:0] wm_neg_lvl = '0;
   logic [CW-1:0] wm_asr_lvl = '0;
   logic auto_rts_en = 1'b1, sw_rts = 1'b0, auto_cts_en = 1'b0, cts_irq_en = 1'b0;
   logic cts_pin = 1'b0, tx_idle = 1'b1, status_rd = 1'b0;
   logic rts_out, tx_hold, cts_flag;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rtsc_flow_ctrl #(.CNT_W(CW)) u_rtsc_flow_ctrl (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .wide_mode(wide_mode),
      .rx_trig_code(rx_trig_code), .wm_neg_lvl(wm_neg_lvl), .wm_asr_lvl(wm_asr_lvl),
      .auto_rts_en(auto_rts_en), .sw_rts(sw_rts), .auto_cts_en(auto_cts_en),
      .cts_irq_en(cts_irq_en), .cts_pin(cts_pin), .tx_idle(tx_idle),
      .status_rd(status_rd), .rts_out(rts_out), .tx_hold(tx_hold), .cts_flag(cts_flag)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_neg(input int c);
      case (c)
         0: return 8;
         1: return 16;
         2: return 24;
         default: return 28;
      endcase
   endfunction

   function automatic int exp_asr(input int c);
      case (c)
         0: return 0;
         1: return 7;
         2: return 15;
         default: return 23;
      endcase
   endfunction

   task automatic t_reset();
      check("R9 rts after reset", rts_out, 1);
      check("R9 flag after reset", cts_flag, 0);
      check("R9 hold after reset", tx_hold, 0);
   endtask

   task automatic t_table();
      auto_rts_en = 1'b1;
      wide_mode = 1'b0;
      for (int c = 0; c < 4; c++) begin
         rx_trig_code = 2'(c);
         rx_level = 0;
         tick();
         rx_level = CW'(exp_neg(c) - 1);
         tick();
         check("R2 below withdraw", rts_out, 1);
         rx_level = CW'(exp_neg(c));
         tick();
         check("R2 withdraw at level", rts_out, 0);
         rx_level = CW'(exp_asr(c) + 1);
         tick();
         check("R3 held above re-assert", rts_out, 0);
         rx_level = CW'(exp_asr(c));
         tick();
         check("R2 re-assert at level", rts_out, 1);
      end
   endtask

   task automatic t_hyst();
      wide_mode = 1'b0;
      rx_trig_code = 2'd2;
      rx_level = 20;
      tick(2);
      check("R3 rising into band keeps asserted", rts_out, 1);
      rx_level = 30;
      tick();
      rx_level = 20;
      tick(2);
      check("R3 falling into band keeps withdrawn", rts_out, 0);
      rx_level = 0;
      tick();
   endtask

   task automatic t_wide();
      wide_mode = 1'b1;
      wm_neg_lvl = 100;
      wm_asr_lvl = 40;
      rx_level = 99;
      tick();
      check("R4 below wide withdraw", rts_out, 1);
      rx_level = 100;
      tick();
      check("R4 wide withdraw", rts_out, 0);
      rx_level = 41;
      tick();
      check("R4 wide held", rts_out, 0);
      rx_level = 40;
      tick();
      check("R4 wide re-assert", rts_out, 1);
      rx_level = 0;
      wide_mode = 1'b0;
      tick();
   endtask

   task automatic t_sw();
      rx_level = 28;
      rx_trig_code = 2'd3;
      tick();
      auto_rts_en = 1'b0;
      sw_rts = 1'b1;
      #1;
      check("R1 software value 1", rts_out, 1);
      sw_rts = 1'b0;
      #1;
      check("R1 software value 0", rts_out, 0);
      auto_rts_en = 1'b1;
      #1;
      check("R1 auto shows withdrawn", rts_out, 0);
      rx_level = 0;
      tick();
   endtask

   task automatic t_flag();
      cts_irq_en = 1'b1;
      cts_pin = 1'b1;
      tick(2);
      check("R5 flag not before third edge", cts_flag, 0);
      tick();
      check("R5 flag on third edge", cts_flag, 1);
      status_rd = 1'b1;
      tick();
      status_rd = 1'b0;
      check("R7 read clears", cts_flag, 0);
      cts_pin = 1'b0;
      tick(4);
   endtask

   task automatic t_mask();
      cts_irq_en = 1'b0;
      cts_pin = 1'b1;
      tick(5);
      check("R6 masked rise", cts_flag, 0);
      cts_pin = 1'b0;
      tick(4);
      cts_irq_en = 1'b1;
   endtask

   task automatic t_race();
      cts_pin = 1'b1;
      tick(2);
      status_rd = 1'b1;
      tick();
      status_rd = 1'b0;
      check("R7 set wins over read", cts_flag, 1);
      status_rd = 1'b1;
      tick();
      status_rd = 1'b0;
      check("R7 later read clears", cts_flag, 0);
      cts_pin = 1'b0;
      tick(4);
   endtask

   task automatic t_hold();
      auto_cts_en = 1'b0;
      cts_pin = 1'b1;
      tick(5);
      check("R8 no hold when disabled", tx_hold, 0);
      cts_pin = 1'b0;
      tick(4);
      auto_cts_en = 1'b1;
      tx_idle = 1'b0;
      cts_pin = 1'b1;
      tick(5);
      check("R8 busy character not held", tx_hold, 0);
      tx_idle = 1'b1;
      tick();
      check("R8 hold at boundary", tx_hold, 1);
      tx_idle = 1'b0;
      tick();
      check("R8 hold kept", tx_hold, 1);
      cts_pin = 1'b0;
      tick(2);
      check("R8 hold before release edge", tx_hold, 1);
      tick();
      check("R8 hold released", tx_hold, 0);
      status_rd = 1'b1;
      tick();
      status_rd = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(2);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_table();
      t_hyst();
      t_wide();
      t_sw();
      t_flag();
      t_mask();
      t_race();
      t_hold();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule